// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps the time of day and the calendar date as packed BCD values. It holds seconds, minutes, hours, day of week, date, month and a two-digit year. A prescaler divides the 32.768 kHz reference clock, which is also the block's clock, down to one advance per second. Each field rolls over into the next. The date field follows the length of the current month, and February has 29 days in any year that is a multiple of four.

A serial front end sits outside this block. While a write transaction is open it holds `hold_count` high and `div_clear` high. It loads fields one at a time through a select-and-data port, and it reads the fields from the output buses. When chip enable drops, the front end releases `div_clear`, and the first second then completes a full division period later.

A comparator outside the block reports low supply as a digital level. The block samples that level once per second into a sticky warning flag. The flag is shown as bit 3 of the day-of-week output. It is cleared by reset and by any load.

Top module: `rtc_calendar`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become 00:00:00, day of week 1, date 01, month 01 and year 00. The flag clears and the prescaler count returns to zero.
- R2: The seconds field advances once every DIV_RATIO clock cycles (32768 by default). The first advance lands on the DIV_RATIO-th edge after reset or after `div_clear` is released.
- R3: Seconds and minutes count in BCD from 00 to 59. Hours count from 00 to 23. At each wrap the field returns to 00 and carries into the next field.
- R4: When hours wrap, the date and the day of week advance together. Day of week runs 1 to 7 and wraps to 1. The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February.
- R5: In February the date wraps after day 29 when the year value is a multiple of 4 (this includes 00). In all other years it wraps after day 28.
- R6: When the date wraps, the month advances, and month 12 wraps to 01. A wrap from month 12 advances the year, and year 99 wraps to 00.
- R7: While `hold_count` is high, no field changes except through a load. A second that completes during the hold is lost.
- R8: While `div_clear` is high, the prescaler is held at zero and no second completes.
- R9: A load in a cycle with `ld_en` high writes `ld_data` into the field chosen by `ld_sel` at that edge. The select codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month and 6 year. Code 7 changes no field. Bits outside the field are forced to zero: seconds and minutes keep 7 bits, hours and date keep 6, day of week keeps 3, month keeps 5 and year keeps 8. No counting happens in a load cycle.
- R10: At each completed second with `supply_low` high, the flag (`dow_o[3]`) sets. It then stays set until reset or a load.
- R11: Any load clears the flag, whatever `ld_sel` is. A load also wins over a low-supply sample taken in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_count | input | 1 | Freezes field counting during a write |
| div_clear | input | 1 | Clears and holds the prescaler |
| ld_en | input | 1 | Field load strobe |
| ld_sel | input | 3 | Field select code for a load |
| ld_data | input | 8 | BCD value to load |
| supply_low | input | 1 | Comparator output, high when the supply is below threshold |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD |
| dow_o | output | 4 | Bit 3 is the low-supply flag, bits 2:0 are the day of week |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
The hardest situations to reach are the cascades that run through every field in one edge: New Year after 23:59:59, 31 December 99, and the February boundaries in leap years and non-leap years. Counting up to these from reset would take years of simulated time. The bench reaches them directly instead. It shrinks DIV_RATIO, holds `div_clear` high while it loads every field to one second before the boundary, and then releases the prescaler. This places the critical advance on a known edge, four cycles later. A behavioural model checks every cycle along the way.

// File: rtl/rtc_cal_pkg.sv
// Package: shared constants and BCD calendar helper functions.
// Assumes all arguments are valid packed BCD values.
package rtc_cal_pkg;

    localparam int NUM_FIELDS = 7;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DOW   = 3'd3,
        FLD_DATE  = 3'd4,
        FLD_MONTH = 3'd5,
        FLD_YEAR  = 3'd6,
        FLD_NONE  = 3'd7
    } fld_sel_e;

    // Next BCD value of a two-digit number; the caller handles the wrap.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // A two-digit BCD year is a multiple of four: the tens digit is even and
    // the ones digit is 0, 4 or 8, or the tens digit is odd and the ones is 2 or 6.
    function automatic logic year_is_leap(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    // Last date of a BCD month, as BCD.
    function automatic logic [7:0] month_last_day(input logic [7:0] m, input logic leap);
        case (m)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Module: divides the reference clock down to a one-cycle pulse per second.
// Assumes DIV_RATIO >= 2. clr clears the count and holds it at zero, and the
// first pulse after clr falls comes on the DIV_RATIO-th edge.
module rtc_prescaler #(
    parameter int DIV_RATIO = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_RATIO - 1);

    logic [CW-1:0] cnt_q;

    // The last count value marks a completed second unless clr holds the divider.
    assign tick = (cnt_q == LAST) && !clr;

    // Count modulo DIV_RATIO; reset and clr force the count to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rtc_bcd_field.sv
// Module: one BCD calendar field with a load port and a wrap value.
// Assumes top_val and loaded data are valid BCD. A load takes priority over inc.
module rtc_bcd_field #(
    parameter logic [7:0] LO   = 8'h00,
    parameter logic [7:0] MASK = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic [7:0] top_val,
    output logic [7:0] q
);
    import rtc_cal_pkg::*;

    // Reset to the low bound, load masked data, or step and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= LO;
        else if (ld)  q <= ld_val & MASK;
        else if (inc) q <= (q == top_val) ? LO : bcd_inc(q);
    end
endmodule

// File: rtl/rtc_lowv_flag.sv
// Module: sticky low-supply warning flag.
// Assumes sample pulses once per second. A clear wins over a set in the same cycle.
module rtc_lowv_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sample,
    input  logic low,
    output logic flag
);
    // Set when a sample sees low supply; only reset or clr clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)     flag <= 1'b0;
        else if (sample && low) flag <= 1'b1;
    end
endmodule

// File: rtl/rtc_calendar.sv
// Module: top of the BCD calendar counter. It ties the prescaler, the seven
// field counters and the flag together and builds the carry chain.
// Assumes loads carry valid BCD within each field's range.
module rtc_calendar #(
    parameter int DIV_RATIO = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_count,
    input  logic       div_clear,
    input  logic       ld_en,
    input  logic [2:0] ld_sel,
    input  logic [7:0] ld_data,
    input  logic       supply_low,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [3:0] dow_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o
);
    import rtc_cal_pkg::*;

    // Per-field reset value and load mask. Index 0 is seconds, 6 is year.
    localparam logic [8*NUM_FIELDS-1:0] LO_PACK =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
    localparam logic [8*NUM_FIELDS-1:0] MASK_PACK =
        {8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F};

    logic                  tick;
    logic                  adv;
    logic                  low_flag;
    logic [7:0]            fld_q   [NUM_FIELDS];
    logic [7:0]            top_val [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] inc_vec;
    logic [NUM_FIELDS-1:0] wrap_vec;
    logic [7:0]            last_day;

    rtc_prescaler #(.DIV_RATIO(DIV_RATIO)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (div_clear),
        .tick (tick)
    );

    // Last date of the current month, given the current year.
    always_comb last_day = month_last_day(fld_q[FLD_MONTH], year_is_leap(fld_q[FLD_YEAR]));

    // Wrap values for each field.
    always_comb begin
        top_val[FLD_SEC]   = 8'h59;
        top_val[FLD_MIN]   = 8'h59;
        top_val[FLD_HOUR]  = 8'h23;
        top_val[FLD_DOW]   = 8'h07;
        top_val[FLD_DATE]  = last_day;
        top_val[FLD_MONTH] = 8'h12;
        top_val[FLD_YEAR]  = 8'h99;
    end

    // A second completes into the fields only when there is no hold and no load.
    assign adv = tick && !hold_count && !ld_en;

    // Carry chain: sec -> min -> hour -> (date, day of week) -> month -> year.
    always_comb begin
        for (int k = 0; k < NUM_FIELDS; k++) wrap_vec[k] = (fld_q[k] == top_val[k]);
        inc_vec[FLD_SEC]   = adv;
        inc_vec[FLD_MIN]   = inc_vec[FLD_SEC]  && wrap_vec[FLD_SEC];
        inc_vec[FLD_HOUR]  = inc_vec[FLD_MIN]  && wrap_vec[FLD_MIN];
        inc_vec[FLD_DOW]   = inc_vec[FLD_HOUR] && wrap_vec[FLD_HOUR];
        inc_vec[FLD_DATE]  = inc_vec[FLD_DOW];
        inc_vec[FLD_MONTH] = inc_vec[FLD_DATE]  && wrap_vec[FLD_DATE];
        inc_vec[FLD_YEAR]  = inc_vec[FLD_MONTH] && wrap_vec[FLD_MONTH];
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        rtc_bcd_field #(
            .LO  (LO_PACK[8*i +: 8]),
            .MASK(MASK_PACK[8*i +: 8])
        ) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc_vec[i]),
            .ld     (ld_en && (ld_sel == 3'(i))),
            .ld_val (ld_data),
            .top_val(top_val[i]),
            .q      (fld_q[i])
        );
    end

    rtc_lowv_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ld_en),
        .sample(tick),
        .low   (supply_low),
        .flag  (low_flag)
    );

    // Drive the output buses; the flag shares the day-of-week output.
    assign sec_o   = fld_q[FLD_SEC];
    assign min_o   = fld_q[FLD_MIN];
    assign hour_o  = fld_q[FLD_HOUR];
    assign dow_o   = {low_flag, fld_q[FLD_DOW][2:0]};
    assign date_o  = fld_q[FLD_DATE];
    assign month_o = fld_q[FLD_MONTH];
    assign year_o  = fld_q[FLD_YEAR];
endmodule

// File: rtl/rtc_calendar_chk.sv
// Module: assertion checker bound to rtc_calendar. It observes ports only.
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hold_count,
    input logic       div_clear,
    input logic       ld_en,
    input logic [2:0] ld_sel,
    input logic [7:0] ld_data,
    input logic       supply_low,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [3:0] dow_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o
);
    assert_sec_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_o[3:0] <= 4'd9) && (sec_o <= 8'h59));

    assert_hour_bcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_o[3:0] <= 4'd9) && (hour_o <= 8'h23));

    assert_dow_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dow_o[2:0] != 3'd0);

    assert_month_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (month_o >= 8'h01) && (month_o <= 8'h12));

    assert_hold_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_count && !ld_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)
            && $stable(dow_o[2:0]) && $stable(date_o) && $stable(month_o) && $stable(year_o)));

    assert_clear_no_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_clear && !ld_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o)));

    assert_load_sec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_sel == 3'd0) |=> (sec_o == ($past(ld_data) & 8'h7F)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dow_o[3] && !ld_en) |=> dow_o[3]);

    assert_load_clears_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> !dow_o[3]);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (.*);

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_count = 1'b0;
    logic       div_clear = 1'b0;
    logic       ld_en = 1'b0;
    logic [2:0] ld_sel = 3'd0;
    logic [7:0] ld_data = 8'h00;
    logic       supply_low = 1'b0;
    logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
    logic [3:0] dow_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit mvalid = 1'b0;
    string cur_req = "R1";

    // Reference model state (binary integers).
    int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr, m_flag, m_cnt;

    always #4 clk = ~clk;

    rtc_calendar #(.DIV_RATIO(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .hold_count(hold_count), .div_clear(div_clear),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data), .supply_low(supply_low),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
        .date_o(date_o), .month_o(month_o), .year_o(year_o)
    );

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int dim(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic model_advance();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_dow = (m_dow == 7) ? 1 : m_dow + 1;
                    if (m_date == dim(m_mon, m_yr)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_yr = (m_yr + 1) % 100;
                        end
                    end else m_date++;
                end
            end
        end
    endtask

    // Behavioural reference, stepped on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1;
            m_mon = 1; m_yr = 0; m_flag = 0; m_cnt = 0;
        end else begin
            automatic bit tk = (m_cnt == DIV - 1) && !div_clear;
            if (div_clear || m_cnt == DIV - 1) m_cnt = 0; else m_cnt++;
            if (ld_en) begin
                m_flag = 0;
                case (ld_sel)
                    3'd0: m_sec  = b2i(ld_data & 8'h7F);
                    3'd1: m_min  = b2i(ld_data & 8'h7F);
                    3'd2: m_hr   = b2i(ld_data & 8'h3F);
                    3'd3: m_dow  = int'(ld_data[2:0]);
                    3'd4: m_date = b2i(ld_data & 8'h3F);
                    3'd5: m_mon  = b2i(ld_data & 8'h1F);
                    3'd6: m_yr   = b2i(ld_data);
                    default: ;
                endcase
            end else begin
                if (tk && supply_low) m_flag = 1;
                if (tk && !hold_count) model_advance();
            end
        end
        mvalid = 1'b1;
    end

    // Compare every field against the model on each falling edge.
    always @(negedge clk) begin
        if (mvalid && !done) begin
            check(cur_req, "sec",   int'(sec_o),   int'(i2b(m_sec)));
            check(cur_req, "min",   int'(min_o),   int'(i2b(m_min)));
            check(cur_req, "hour",  int'(hour_o),  int'(i2b(m_hr)));
            check(cur_req, "dow",   int'(dow_o),   m_flag * 8 + m_dow);
            check(cur_req, "date",  int'(date_o),  int'(i2b(m_date)));
            check(cur_req, "month", int'(month_o), int'(i2b(m_mon)));
            check(cur_req, "year",  int'(year_o),  int'(i2b(m_yr)));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [2:0] sel, input logic [7:0] d);
        ld_en = 1'b1; ld_sel = sel; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Hold the divider, load all fields, release; the advance lands 4 edges later.
    task automatic set_and_run(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                               input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mi,
                               input logic [7:0] se);
        div_clear = 1'b1;
        load(3'd6, yr); load(3'd5, mo); load(3'd4, dt); load(3'd3, dw);
        load(3'd2, hr); load(3'd1, mi); load(3'd0, se);
        div_clear = 1'b0;
        step(DIV);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] snap;
        // R1: reset state
        step(3);
        check("R1", "reset sec", int'(sec_o), 0);
        check("R1", "reset dow", int'(dow_o), 1);
        check("R1", "reset date", int'(date_o), 1);
        check("R1", "reset month", int'(month_o), 1);
        rst_n = 1'b1;
        // R2: first advance on the DIV-th edge after release
        cur_req = "R2";
        step(DIV - 1);
        check("R2", "sec before period", int'(sec_o), 8'h00);
        step(1);
        check("R2", "sec after period", int'(sec_o), 8'h01);
        step(DIV * 20);
        // R3/R4/R6: full cascade at the end of the century
        cur_req = "R6";
        set_and_run(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
        check("R3", "sec wrap", int'(sec_o), 8'h00);
        check("R3", "hour wrap", int'(hour_o), 8'h00);
        check("R4", "dow 7->1", int'(dow_o), 1);
        check("R6", "month 12->01", int'(month_o), 8'h01);
        check("R6", "year 99->00", int'(year_o), 8'h00);
        // R5: leap February
        cur_req = "R5";
        set_and_run(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        check("R5", "leap feb 29", int'(date_o), 8'h29);
        check("R4", "dow with date", int'(dow_o), 4);
        set_and_run(8'h24, 8'h02, 8'h29, 8'h04, 8'h23, 8'h59, 8'h59);
        check("R5", "leap feb end month", int'(month_o), 8'h03);
        set_and_run(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        check("R5", "common feb end date", int'(date_o), 8'h01);
        check("R5", "common feb end month", int'(month_o), 8'h03);
        set_and_run(8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
        check("R5", "year 00 leap", int'(date_o), 8'h29);
        // R4: 30- and 31-day months
        cur_req = "R4";
        set_and_run(8'h51, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
        check("R4", "april end", int'(month_o), 8'h05);
        set_and_run(8'h51, 8'h01, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
        check("R4", "january 31", int'(date_o), 8'h31);
        step(DIV * 70);
        // R7: hold freezes counting
        cur_req = "R7";
        hold_count = 1'b1;
        snap = sec_o;
        step(DIV * 3 + 1);
        check("R7", "sec held", int'(sec_o), int'(snap));
        hold_count = 1'b0;
        step(DIV * 2);
        // R8: divider clear
        cur_req = "R8";
        div_clear = 1'b1;
        snap = sec_o;
        step(DIV * 3);
        check("R8", "sec under clear", int'(sec_o), int'(snap));
        div_clear = 1'b0;
        step(DIV - 1);
        check("R8", "no early second", int'(sec_o), int'(snap));
        // R10: flag sets and sticks
        cur_req = "R10";
        supply_low = 1'b1;
        step(DIV + 1);
        check("R10", "flag set", int'(dow_o[3]), 1);
        supply_low = 1'b0;
        step(DIV * 3);
        check("R10", "flag sticky", int'(dow_o[3]), 1);
        // R11/R9: code 7 load clears flag and changes no field
        cur_req = "R11";
        div_clear = 1'b1;
        step(1);
        snap = min_o;
        load(3'd7, 8'h00);
        check("R11", "flag cleared by load", int'(dow_o[3]), 0);
        check("R9", "code 7 leaves min", int'(min_o), int'(snap));
        // R9: masking
        cur_req = "R9";
        load(3'd3, 8'hFF);
        check("R9", "dow masked", int'(dow_o), 7);
        load(3'd2, 8'hE3);
        check("R9", "hour masked", int'(hour_o), 8'h23);
        div_clear = 1'b0;
        // R11: load and low sample in the same cycle
        cur_req = "R11";
        supply_low = 1'b1;
        step(DIV - 1);
        load(3'd0, 8'h10);
        check("R11", "load beats sample", int'(dow_o[3]), 0);
        step(DIV * 4);
        supply_low = 1'b0;
        step(DIV * 10);
        summary();
    end
endmodule